// File: doc/BRIEF.md
# Integer Square Root Unit

This block is a register-mapped unit that returns the floor of the square root of an unsigned operand. Software writes the operand in bus-sized words, along with a control word holding a width-select bit. Any write to the control word or to an operand word launches a new computation and raises a busy flag. The datapath is iterative and retires two operand bits per clock.

Its seed stage finds the largest power of four that does not exceed the operand. From there a shift-subtract loop compares a running remainder against the partial root plus the trial bit. Each clock it either subtracts and folds the trial bit into the root, or only halves the root. The trial bit then moves down by two places. When the trial bit runs out, the low half of the partial root is copied into the result register and busy drops.

In the narrow mode only the low half of the operand is used. The result register keeps its last value until a computation actually completes.

Top module: `isqrt_unit`

## Requirements
- R1: After reset the busy flag is 0, and every register location (control, operand words, result) reads 0.
- R2: A write to address 0 (control) or to any operand address (1 = operand bits 31:0, 2 = operand bits 63:32) starts a computation. Control bit 15 and the `busy` port read 1 in the first cycle after the write.
- R3: Control bit 0 = 1 selects the full 64-bit operand. Control bit 0 = 0 uses only operand bits 31:0, and the upper bits act as zero.
- R4: On completion the result (address 3, bits 31:0, lowest-order word first) equals the floor of the square root of the effective operand. An operand of zero gives zero.
- R5: Busy stays high for exactly floor(log4(x))+1 cycles for an effective operand x > 0, and for 1 cycle when x = 0. It is never high for more than 32 cycles.
- R6: A start write while busy abandons the running computation and restarts it from the updated registers. This holds even in the cycle the old computation would have finished: the abandoned result is never written.
- R7: A write to the result address has no effect: no start, and the result is unchanged. Control bits other than bit 0 are not stored. The control word reads with bit 15 = busy, bit 0 = width select, and all other bits 0.
- R8: The result register changes only when a computation completes. During a computation it still reads the previous result.
- R9: Operand words read back at their own addresses exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Write word address |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (2) | Read word address |
| rd_data | output | DATA_W (32) | Read data, combinational from rd_addr |
| busy | output | 1 | High while a computation runs |

## Verification
Completion of the final iteration and a restarting write can land on the same clock edge. In that case the restart must win, and the stale root must never reach the result register. The bench provokes this with an operand whose latency is known to be three cycles, then issues a fresh operand write in exactly the third busy cycle. It judges the outcome by three observations: busy stays high, the result still holds the root from before the abandoned run, and the later completion delivers the root and latency of the new operand.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

   localparam int unsigned CTRL_W        = 16;
   localparam int unsigned CTRL_WIDE_BIT = 0;
   localparam int unsigned CTRL_BUSY_BIT = 15;

   typedef enum logic [1:0] {
      KIND_CTRL,
      KIND_ARG,
      KIND_ROOT,
      KIND_NONE
   } reg_kind_e;

   typedef enum logic {
      SQ_IDLE,
      SQ_RUN
   } sq_state_e;

   // Word map: control, then operand words low first, then the root.
   function automatic reg_kind_e decode_kind(input int unsigned idx,
                                             input int unsigned arg_words);
      if (idx == 0)                   return KIND_CTRL;
      else if (idx <= arg_words)      return KIND_ARG;
      else if (idx == arg_words + 1)  return KIND_ROOT;
      else                            return KIND_NONE;
   endfunction

endpackage

// File: rtl/isqrt_regs.sv
module isqrt_regs
   import isqrt_pkg::*;
#(
   parameter int unsigned ARG_W  = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [ARG_W-1:0]  arg_q,
   output logic              wide_q,
   output logic              start,
   output logic [ARG_W-1:0]  eff_next,
   output logic [ARG_W-1:0]  eff_q
);

   localparam int unsigned ARG_WORDS = ARG_W / DATA_W;
   localparam int unsigned NARROW_W  = ARG_W / 2;

   reg_kind_e              wr_kind;
   logic                   ctrl_hit;
   logic                   wide_nxt;
   logic [ARG_WORDS-1:0]   word_hit;
   logic [ARG_W-1:0]       arg_nxt;

   assign wr_kind  = decode_kind(int'(wr_addr), ARG_WORDS);
   assign ctrl_hit = wr_en && (wr_kind == KIND_CTRL);
   assign wide_nxt = ctrl_hit ? wr_data[CTRL_WIDE_BIT] : wide_q;

   generate
      for (genvar w = 0; w < ARG_WORDS; w++) begin : g_word
         assign word_hit[w] = wr_en && (wr_addr == ADDR_W'(w + 1));
         assign arg_nxt[w*DATA_W +: DATA_W] =
            word_hit[w] ? wr_data : arg_q[w*DATA_W +: DATA_W];
      end
   endgenerate

   assign start = ctrl_hit || (|word_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arg_q  <= '0;
         wide_q <= 1'b0;
      end else begin
         arg_q  <= arg_nxt;
         wide_q <= wide_nxt;
      end
   end

   // Width select: the narrow view zeroes the upper half of the operand.
   assign eff_next = wide_nxt ? arg_nxt : {{(ARG_W-NARROW_W){1'b0}}, arg_nxt[NARROW_W-1:0]};
   assign eff_q    = wide_q   ? arg_q   : {{(ARG_W-NARROW_W){1'b0}}, arg_q[NARROW_W-1:0]};

   p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(arg_q) && $stable(wide_q)))
      else $error("operand or width select changed without a write");

   p_start_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_kind != KIND_ROOT) && (wr_kind != KIND_NONE)) |-> start)
      else $error("mapped write did not launch a computation");

endmodule

// File: rtl/isqrt_seed.sv
module isqrt_seed #(
   parameter int unsigned ARG_W = 64
) (
   input  logic [ARG_W-1:0] operand,
   output logic [ARG_W-1:0] trial
);

   localparam int unsigned PAIRS = ARG_W / 2;

   logic [PAIRS-1:0] pair_nz;

   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         assign pair_nz[p] = |operand[2*p +: 2];
      end
   endgenerate

   // Highest non-empty bit pair picks the starting power of four.
   always_comb begin
      trial = '0;
      for (int p = 0; p < PAIRS; p++) begin
         if (pair_nz[p]) trial = ARG_W'(1) << (2 * p);
      end
   end

endmodule

// File: rtl/isqrt_core.sv
module isqrt_core
   import isqrt_pkg::*;
#(
   parameter int unsigned ARG_W = 64,
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ARG_W-1:0] operand,
   input  logic [ARG_W-1:0] seed,
   output logic             busy,
   output logic             last_step,
   output logic [RES_W-1:0] root
);

   localparam int unsigned CNT_W = $clog2(RES_W) + 2;

   sq_state_e        state_q;
   logic [ARG_W-1:0] rem_q, acc_q, trial_q;
   logic [ARG_W-1:0] rem_n, acc_n;
   logic [ARG_W:0]   sum;
   logic             take;
   logic [RES_W-1:0] root_q;

   assign busy      = (state_q == SQ_RUN);
   assign last_step = busy && (trial_q[ARG_W-1:2] == '0);
   assign root      = root_q;

   assign sum   = {1'b0, acc_q} + {1'b0, trial_q};
   assign take  = ({1'b0, rem_q} >= sum);
   assign rem_n = take ? (rem_q - sum[ARG_W-1:0]) : rem_q;
   assign acc_n = take ? ((acc_q >> 1) + trial_q) : (acc_q >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         rem_q   <= '0;
         acc_q   <= '0;
         trial_q <= '0;
         root_q  <= '0;
      end else if (start) begin
         state_q <= SQ_RUN;
         rem_q   <= operand;
         acc_q   <= '0;
         trial_q <= seed;
      end else if (busy) begin
         rem_q   <= rem_n;
         acc_q   <= acc_n;
         trial_q <= trial_q >> 2;
         if (last_step) begin
            state_q <= SQ_IDLE;
            root_q  <= acc_n[RES_W-1:0];
         end
      end
   end

   // Checker-only cycle counter for the latency bound.
   logic [CNT_W-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= '0;
      else if (start)  run_cnt <= CNT_W'(1);
      else if (busy)   run_cnt <= run_cnt + CNT_W'(1);
   end

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy)
      else $error("start did not raise busy");

   p_latency_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt <= CNT_W'(RES_W)))
      else $error("computation ran past the iteration bound");

   p_trial_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trial_q))
      else $error("trial bit is not a single power of four");

   p_idle_root_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(root_q))
      else $error("result changed while idle");

   p_restart_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> $stable(root_q))
      else $error("abandoned computation wrote the result");

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit
   import isqrt_pkg::*;
#(
   parameter int unsigned ARG_W  = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = $clog2(ARG_W / DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);

   localparam int unsigned RES_W     = ARG_W / 2;
   localparam int unsigned ARG_WORDS = ARG_W / DATA_W;

   generate
      if ((ARG_W % 2) != 0 || ARG_W < 4) begin : g_bad_arg
         $error("operand width must be even and at least 4");
      end
      if ((ARG_W % DATA_W) != 0) begin : g_bad_split
         $error("operand width must be a whole number of bus words");
      end
      if (RES_W > DATA_W || DATA_W < CTRL_W) begin : g_bad_bus
         $error("bus too narrow for the result or the control word");
      end
      if ((1 << ADDR_W) < (ARG_WORDS + 2)) begin : g_bad_addr
         $error("address width cannot reach every register");
      end
   endgenerate

   logic [ARG_W-1:0] arg_q, eff_next, eff_q, seed;
   logic             wide_q, start, last_step;
   logic [RES_W-1:0] root;

   isqrt_regs #(.ARG_W(ARG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .arg_q    (arg_q),
      .wide_q   (wide_q),
      .start    (start),
      .eff_next (eff_next),
      .eff_q    (eff_q)
   );

   isqrt_seed #(.ARG_W(ARG_W)) u_seed (
      .operand (eff_next),
      .trial   (seed)
   );

   isqrt_core #(.ARG_W(ARG_W), .RES_W(RES_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .operand   (eff_next),
      .seed      (seed),
      .busy      (busy),
      .last_step (last_step),
      .root      (root)
   );

   int unsigned rd_idx;
   assign rd_idx = int'(rd_addr);

   always_comb begin
      rd_data = '0;
      unique case (decode_kind(rd_idx, ARG_WORDS))
         KIND_CTRL: begin
            rd_data[CTRL_BUSY_BIT] = busy;
            rd_data[CTRL_WIDE_BIT] = wide_q;
         end
         KIND_ARG:  rd_data = arg_q[(rd_idx - 1) * DATA_W +: DATA_W];
         KIND_ROOT: rd_data[RES_W-1:0] = root;
         default:   rd_data = '0;
      endcase
   end

   // Assertion support: bracket the finished root by its squares.
   logic [ARG_W+1:0] sq_lo, sq_hi;
   assign sq_lo = (ARG_W+2)'(root) * (ARG_W+2)'(root);
   assign sq_hi = ((ARG_W+2)'(root) + 1) * ((ARG_W+2)'(root) + 1);

   p_root_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (last_step && !start) |=> ((sq_lo <= (ARG_W+2)'(eff_q)) && (sq_hi > (ARG_W+2)'(eff_q))))
      else $error("finished root is not the floor square root");

   p_finish_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_step && !start) |=> !busy)
      else $error("busy held after the final iteration");

endmodule

// File: tb/tb_isqrt_unit.sv
module tb_isqrt_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [31:0] wr_data;
   logic [1:0]  rd_addr;
   logic [31:0] rd_data;
   logic        busy;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   isqrt_unit dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .busy    (busy)
   );

   function automatic logic [31:0] ref_root(input logic [63:0] x);
      logic [32:0] lo, hi, mid;
      logic [65:0] sq;
      lo = 33'd0;
      hi = 33'h1_0000_0000;
      while (hi - lo > 1) begin
         mid = (lo + hi) >> 1;
         sq  = 66'(mid) * 66'(mid);
         if (sq <= 66'(x)) lo = mid;
         else              hi = mid;
      end
      return lo[31:0];
   endfunction

   function automatic int ref_lat(input logic [63:0] x);
      int n;
      if (x == 64'd0) return 1;
      n = 0;
      while (x != 64'd0) begin
         x = x >> 2;
         n++;
      end
      return n;
   endfunction

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Caller sits at a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run(input logic [63:0] x, input bit wide,
                      output int lat, output logic [31:0] r);
      wr(2'd1, x[31:0]);
      wr(2'd2, x[63:32]);
      wr(2'd0, {31'd0, wide});
      wait_idle(lat);
      rd(2'd3, r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R5: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int          lat;
      logic [31:0] r, v;
      logic [63:0] x, eff;

      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 32'd0, "R1 register", v, 0);
      end

      // R2: start raises busy and control bit 15
      wr(2'd1, 32'd49);
      rd(2'd0, v);
      chk(busy == 1'b1 && v == 32'h0000_8000, "R2 busy after start", v, 32'h8000);
      wait_idle(lat);
      rd(2'd3, v);
      chk(v == 32'd7, "R4 root of 49", v, 7);

      // R3/R4/R5: narrow sweep with junk in the upper operand word
      for (int i = 0; i < 1200; i++) begin
         x   = {32'(i) * 32'h9E37, 32'(i)};
         eff = {32'd0, x[31:0]};
         run(x, 1'b0, lat, r);
         chk(r == ref_root(eff), "R3 R4 narrow root", r, ref_root(eff));
         chk(lat == ref_lat(eff), "R5 narrow latency", lat, ref_lat(eff));
      end

      // R4/R5: wide operands around perfect squares
      for (int i = 0; i < 64; i++) begin
         logic [63:0] k;
         k = ((64'(i) * 64'd2654435761) & 64'hFFFF_FFFF) | 64'd1;
         for (int d = -1; d <= 1; d++) begin
            x = k * k + 64'(d);
            run(x, 1'b1, lat, r);
            chk(r == ref_root(x), "R4 wide root", r, ref_root(x));
            chk(lat == ref_lat(x), "R5 wide latency", lat, ref_lat(x));
         end
      end

      // R4: powers of four and the top of the range
      run(64'h4000_0000_0000_0000, 1'b1, lat, r);
      chk(r == 32'h8000_0000, "R4 two pow 62", r, 32'h8000_0000);
      run(64'h8000_0000_0000_0000, 1'b1, lat, r);
      chk(r == ref_root(64'h8000_0000_0000_0000), "R4 two pow 63", r,
          ref_root(64'h8000_0000_0000_0000));
      run(64'h0, 1'b1, lat, r);
      chk(r == 32'd0 && lat == 1, "R4 R5 zero operand", {r, 32'(lat)}, 64'h1);

      // R3: the same operand in both modes
      x = 64'h0123_4567_0000_0090;
      run(x, 1'b0, lat, r);
      chk(r == 32'd12, "R3 narrow mask", r, 12);
      run(x, 1'b1, lat, r);
      chk(r == ref_root(x), "R3 wide select", r, ref_root(x));

      // R9: operand words read back
      rd(2'd1, v);
      chk(v == 32'h0000_0090, "R9 operand low", v, 32'h90);
      rd(2'd2, v);
      chk(v == 32'h0123_4567, "R9 operand high", v, 32'h0123_4567);

      // R6/R8: restart mid-run, old result visible until completion
      run(64'd144, 1'b0, lat, r);
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, 32'd1);
      repeat (5) @(negedge clk);
      rd(2'd3, v);
      chk(v == 32'd12 && busy, "R8 old result during run", v, 12);
      wr(2'd0, 32'd0);
      wait_idle(lat);
      rd(2'd3, v);
      chk(v == 32'd65535, "R6 restart root", v, 65535);
      chk(lat == 16, "R6 restart latency", lat, 16);

      // R7: write to result address is ignored
      wr(2'd3, 32'h1234);
      chk(busy == 1'b0, "R7 no start", busy, 0);
      rd(2'd3, v);
      chk(v == 32'd65535, "R7 result kept", v, 65535);

      // R7/R5: only bit 0 of control is stored; full-range latency
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v);
      chk(v == 32'h0000_8001, "R7 control readback", v, 32'h8001);
      wait_idle(lat);
      rd(2'd3, v);
      chk(v == 32'hFFFF_FFFF, "R4 all ones root", v, 32'hFFFF_FFFF);
      chk(lat == 32, "R5 max latency", lat, 32);

      // R6: restart on the very edge the old run would finish
      run(64'd49, 1'b0, lat, r);
      wr(2'd2, 32'd0);
      wr(2'd1, 32'd16);
      @(negedge clk);
      @(negedge clk);
      wr(2'd1, 32'd100);
      rd(2'd3, v);
      chk(busy && v == 32'd7, "R6 collision keeps old result", v, 7);
      wait_idle(lat);
      rd(2'd3, v);
      chk(v == 32'd10, "R6 collision new root", v, 10);
      chk(lat == 4, "R6 collision latency", lat, 4);

      finish_run();
   end

endmodule